// File: doc/BRIEF.md
# Parallel Slave Port Controller

This block lets an external master read and write one or two byte-wide data lanes of a microcontroller as if they were a memory device. The master selects the slave with an active-low chip select and picks the transfer direction with a read/write input: high means the master reads, low means it writes. Both inputs are synchronized through two flip-flops. A high-to-low transition of the synchronized chip select starts exactly one transfer. It produces a one-cycle start event for the processor and sets a sticky start flag.

An optional open-drain wait output stalls the master while local software moves data. It is armed in hardware when a transfer starts and is released only when software writes 1 to a self-clearing ready bit. On a master write, the block captures the enabled lanes into receive registers for software. On a master read, the block drives the transmit data that software has written onto the enabled lanes. A single configuration register holds the lane enables and the wait enable. These enables also serve as the direction overrides for the port pins.

Top module: `psp_ctrl`

## Requirements
- R1: After reset, `cfg_rdata_o` reads 0, `start_o`, `hold_oe_o`, `lane_oe_o`, `dir_ovr_o`, `hold_dir_o` and `xfer_rd_o` are 0, and `rxd_o`/`lane_o` are 0.
- R2: A high-to-low change of `cs_n_i` that is seen before clock edge k gives `start_o` high for exactly the one cycle after edge k+1. From edge k+2 on, the start flag (configuration bit 4) reads 1. The flag is cleared by writing 1 to bit 4. If a clear and a new start fall on the same edge, the start wins.
- R3: Only one start occurs per chip-select assertion. A `cs_n_i` held low for any length gives one pulse. A `cs_n_i` that is already low when reset is released gives no pulse until it goes high and falls again.
- R4: When the wait enable (configuration bit 2) is 1 at the start, `hold_oe_o` (1 = drive the wait pin low) goes high from edge k+2. When the enable is 0, it stays low.
- R5: `hold_oe_o` is 0 whenever `cs_n_i` is 1, whatever the internal pending state.
- R6: Writing 1 to the ready bit (configuration bit 3) clears a pending wait, so `hold_oe_o` drops after that edge. The bit always reads 0. A ready write while nothing is pending has no effect: the next start still asserts `hold_oe_o`.
- R7: `lane_oe_o[i]` is 1 exactly when lane i is enabled (configuration bit i), `cs_n_i` is 0 and `rw_i` is 1. `lane_o` always carries the last data written through `txd_we_i`.
- R8: During an accepted write transfer (synchronized chip select low, synchronized read/write low), each enabled lane loads `lane_i` into its byte of `rxd_o` on every clock. Disabled lanes, and all lanes outside such a transfer, hold their value.
- R9: `dir_ovr_o` and `hold_dir_o` follow the lane and wait enables from the edge on which the configuration write is taken.
- R10: `xfer_rd_o` holds the synchronized read/write value sampled at the last start, and it reads 1 for a master read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Master chip select, active low, asynchronous |
| rw_i | input | 1 | Master direction, 1 = master reads |
| lane_i | input | 16 | Data from the lane pads |
| lane_o | output | 16 | Data to drive on the lane pads |
| lane_oe_o | output | 2 | Per-lane pad output enable |
| hold_oe_o | output | 1 | Wait pin pull-low enable (open-drain) |
| dir_ovr_o | output | 2 | Per-lane direction override active |
| hold_dir_o | output | 1 | Wait pin direction override active |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 5 | Configuration write data |
| cfg_rdata_o | output | 5 | Configuration read data |
| txd_we_i | input | 1 | Transmit data write strobe |
| txd_i | input | 16 | Transmit data from software |
| rxd_o | output | 16 | Data captured from master writes |
| start_o | output | 1 | One-cycle transfer-start event |
| xfer_rd_o | output | 1 | Direction of the current transfer |

## Verification
The hardest situations to reach are the ones where the wait state and the chip select disagree. One is a pending wait left over when the master deasserts chip select before software releases it. The other is a ready write issued while nothing is pending. The stimulus raises chip select while a wait is still pending and checks that the output floats. Then it writes the ready bit with no wait pending and starts a new transfer, to confirm that the wait still asserts. A chip select held low through reset, and one held low for many cycles, show that only a true falling edge starts a transfer.

// File: rtl/psp_pkg.sv
// Package: shared constants and types for the parallel slave port.
// Assumes byte-wide lanes; lane count is a parameter of the users.
package psp_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        XFER_MASTER_WR = 1'b0,
        XFER_MASTER_RD = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/psp_sync.sv
// Module: multi-stage synchronizer for one asynchronous input.
// Assumes STAGES >= 2. Resets to 0 (the "asserted" level of chip select),
// so an input held low through reset is not mistaken for a new edge.
module psp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flip-flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/psp_ctl.sv
// Module: configuration register, transfer start detection and wait state.
// Assumes synchronized chip select and direction inputs. Configuration layout:
// [LANES-1:0] lane enables, [LANES] wait enable, [LANES+1] ready (write 1,
// reads 0), [LANES+2] sticky start flag (write 1 to clear).
module psp_ctl #(
    parameter int LANES = 2,
    localparam int HOLD_BIT = LANES,
    localparam int RDY_BIT  = LANES + 1,
    localparam int FLAG_BIT = LANES + 2,
    localparam int CFG_W    = LANES + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s_i,
    input  logic             rw_s_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    output logic [LANES-1:0] lane_en_o,
    output logic             hold_en_o,
    output logic             hold_pend_o,
    output logic             active_o,
    output logic             start_o,
    output logic             xfer_rd_o
);
    import psp_pkg::*;

    logic      cs_prev;
    logic      fall;
    logic      rdy_wr;
    logic      clr_wr;
    logic      flag;
    xfer_dir_e dir_q;

    assign fall   = cs_prev & ~cs_s_i;
    assign rdy_wr = cfg_we_i & cfg_wdata_i[RDY_BIT];
    assign clr_wr = cfg_we_i & cfg_wdata_i[FLAG_BIT];

    // Remember the previous synchronized chip select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_prev <= 1'b0;
        else        cs_prev <= cs_s_i;
    end

    // Software-written enables; they double as direction overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_en_o <= '0;
            hold_en_o <= 1'b0;
        end else if (cfg_we_i) begin
            lane_en_o <= cfg_wdata_i[LANES-1:0];
            hold_en_o <= cfg_wdata_i[HOLD_BIT];
        end
    end

    // Wait pending: armed at a start, released only by the ready bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_pend_o <= 1'b0;
        else if (fall && hold_en_o)  hold_pend_o <= 1'b1;
        else if (rdy_wr)             hold_pend_o <= 1'b0;
    end

    // Sticky start flag, a start wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (fall)   flag <= 1'b1;
        else if (clr_wr) flag <= 1'b0;
    end

    // Transfer window and its direction, opened at a start, closed by chip select high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            dir_q    <= XFER_MASTER_WR;
        end else if (fall) begin
            active_o <= 1'b1;
            dir_q    <= xfer_dir_e'(rw_s_i);
        end else if (cs_s_i) begin
            active_o <= 1'b0;
        end
    end

    assign start_o   = fall;
    assign xfer_rd_o = (dir_q == XFER_MASTER_RD);

    // Read-back view: ready bit always reads as 0.
    always_comb begin
        cfg_rdata_o                 = '0;
        cfg_rdata_o[LANES-1:0]      = lane_en_o;
        cfg_rdata_o[HOLD_BIT]       = hold_en_o;
        cfg_rdata_o[RDY_BIT]        = 1'b0;
        cfg_rdata_o[FLAG_BIT]       = flag;
    end

    // R2
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    // R2
    start_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> cfg_rdata_o[FLAG_BIT]);
    // R4
    start_arms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && hold_en_o) |=> hold_pend_o);
    // R6
    idle_ready_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_pend_o && rdy_wr && !start_o) |=> !hold_pend_o);
    // R9
    enables_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we_i |=> $stable(lane_en_o) && $stable(hold_en_o));
endmodule

// File: rtl/psp_lane.sv
// Module: one byte lane: capture from the master and pad output enable.
// Assumes the master keeps its data stable while chip select is low.
module psp_lane #(
    parameter int W = psp_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         cap_i,
    input  logic         drive_i,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] rx_o,
    output logic         oe_o
);
    // Load pad data during an accepted master write on an enabled lane.
    always_ff @(posedge clk) begin
        if (!rst_n)             rx_o <= '0;
        else if (cap_i && en_i) rx_o <= pad_i;
    end

    assign oe_o = en_i & drive_i;

    // R8
    lane_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_i && en_i) |=> $stable(rx_o));
endmodule

// File: rtl/psp_ctrl.sv
// Module: parallel slave port top. Synchronizes master controls, holds the
// transmit data, instantiates one psp_lane per byte lane and forms the
// open-drain wait enable. Assumes pads apply lane_oe_o / hold_oe_o directly.
module psp_ctrl #(
    parameter int LANES = 2,
    parameter int SYNC  = 2,
    localparam int W     = psp_pkg::BYTE_W,
    localparam int DW    = LANES * W,
    localparam int CFG_W = LANES + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             rw_i,
    input  logic [DW-1:0]    lane_i,
    output logic [DW-1:0]    lane_o,
    output logic [LANES-1:0] lane_oe_o,
    output logic             hold_oe_o,
    output logic [LANES-1:0] dir_ovr_o,
    output logic             hold_dir_o,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    input  logic             txd_we_i,
    input  logic [DW-1:0]    txd_i,
    output logic [DW-1:0]    rxd_o,
    output logic             start_o,
    output logic             xfer_rd_o
);
    logic             cs_s, rw_s;
    logic [LANES-1:0] lane_en;
    logic             hold_en, hold_pend, active;
    logic             cap, drive;
    logic [DW-1:0]    txd_q;

    psp_sync #(.STAGES(SYNC)) u_cs_sync (.clk(clk), .rst_n(rst_n), .d_i(cs_n_i), .q_o(cs_s));
    psp_sync #(.STAGES(SYNC)) u_rw_sync (.clk(clk), .rst_n(rst_n), .d_i(rw_i),   .q_o(rw_s));

    psp_ctl #(.LANES(LANES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .cs_s_i(cs_s), .rw_s_i(rw_s),
        .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .lane_en_o(lane_en), .hold_en_o(hold_en), .hold_pend_o(hold_pend),
        .active_o(active), .start_o(start_o), .xfer_rd_o(xfer_rd_o)
    );

    // Transmit data written by software for master reads.
    always_ff @(posedge clk) begin
        if (!rst_n)        txd_q <= '0;
        else if (txd_we_i) txd_q <= txd_i;
    end

    assign cap   = active & ~cs_s & ~rw_s;
    assign drive = ~cs_n_i & rw_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        psp_lane #(.W(W)) u_lane (
            .clk(clk), .rst_n(rst_n), .en_i(lane_en[g]), .cap_i(cap), .drive_i(drive),
            .pad_i(lane_i[g*W +: W]), .rx_o(rxd_o[g*W +: W]), .oe_o(lane_oe_o[g])
        );
    end

    assign lane_o     = txd_q;
    assign dir_ovr_o  = lane_en;
    assign hold_dir_o = hold_en;
    assign hold_oe_o  = hold_en & hold_pend & ~cs_n_i;

    // R5
    hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_oe_o |-> !cs_n_i);
    // R7
    lane_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_oe_o) |-> (rw_i && !cs_n_i));
endmodule

// File: tb/sim_psp_ctrl.sv
// Bench: behavioural reference model, compared with the design every clock.
module sim_psp_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n_i = 1'b0, rw_i = 1'b0;
    logic [15:0] lane_i = '0, txd_i = '0;
    logic        cfg_we_i = 1'b0, txd_we_i = 1'b0;
    logic [4:0]  cfg_wdata_i = '0;
    logic [15:0] lane_o, rxd_o;
    logic [1:0]  lane_oe_o, dir_ovr_o;
    logic        hold_oe_o, hold_dir_o, start_o, xfer_rd_o;
    logic [4:0]  cfg_rdata_o;

    int checks = 0, fails = 0, cycles = 0, starts = 0;
    bit done = 0;

    psp_ctrl u0 (.*);

    always #5 clk = ~clk;

    // reference state
    bit [2:0]  csh, rwh;
    bit [1:0]  m_en;
    bit        m_hen, m_pend, m_flag, m_act, m_xrd;
    bit [15:0] m_txd, m_rxd;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        bit fall;
        cycles++;
        if (!rst_n) begin
            csh = '0; rwh = '0; m_en = '0; m_hen = 0; m_pend = 0; m_flag = 0;
            m_act = 0; m_xrd = 0; m_txd = '0; m_rxd = '0;
        end else begin
            fall = csh[2] && !csh[1];
            for (int i = 0; i < 2; i++)
                if (m_act && !csh[1] && !rwh[1] && m_en[i]) m_rxd[i*8 +: 8] = lane_i[i*8 +: 8];
            if (fall && m_hen) m_pend = 1;
            else if (cfg_we_i && cfg_wdata_i[3]) m_pend = 0;
            if (fall) m_flag = 1;
            else if (cfg_we_i && cfg_wdata_i[4]) m_flag = 0;
            if (fall) begin m_act = 1; m_xrd = rwh[1]; end
            else if (csh[1]) m_act = 0;
            if (cfg_we_i) begin m_en = cfg_wdata_i[1:0]; m_hen = cfg_wdata_i[2]; end
            if (txd_we_i) m_txd = txd_i;
            csh = {csh[1:0], cs_n_i};
            rwh = {rwh[1:0], rw_i};
        end
        #2;
        if (rst_n && !done) begin
            if (start_o) starts++;
            check("R2", "start_o", start_o, csh[2] && !csh[1]);
            check("R4/R5", "hold_oe_o", hold_oe_o, m_hen && m_pend && !cs_n_i);
            check("R7", "lane_oe_o", lane_oe_o, m_en & {2{!cs_n_i && rw_i}});
            check("R7", "lane_o", lane_o, m_txd);
            check("R8", "rxd_o", rxd_o, m_rxd);
            check("R6", "cfg_rdata_o", cfg_rdata_o, {m_flag, 1'b0, m_hen, m_en});
            check("R9", "dir_ovr_o", {hold_dir_o, dir_ovr_o}, {m_hen, m_en});
            check("R10", "xfer_rd_o", xfer_rd_o, m_xrd);
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(logic [4:0] v);
        @(negedge clk); cfg_we_i = 1; cfg_wdata_i = v;
        @(negedge clk); cfg_we_i = 0; cfg_wdata_i = '0;
    endtask

    initial begin
        // R1: reset with chip select held low
        wait_cyc(3);
        rst_n = 1;
        #2;
        check("R1", "reset cfg", cfg_rdata_o, 0);
        check("R1", "reset outs", {start_o, hold_oe_o, lane_oe_o, dir_ovr_o, hold_dir_o, xfer_rd_o}, 0);
        check("R1", "reset data", {rxd_o, lane_o}, 0);
        // R3: low chip select at reset release gives no start
        wait_cyc(8);
        check("R3", "no start after reset", starts, 0);
        cs_n_i = 1; wait_cyc(4);
        // R9: enable both lanes and the wait
        cfg_write(5'b00111);
        // master write, wait asserted until ready
        lane_i = 16'hA55A; rw_i = 0; cs_n_i = 0;
        wait_cyc(8);
        check("R4", "wait held", hold_oe_o, 1);
        check("R8", "captured", rxd_o, 16'hA55A);
        cfg_write(5'b01111);   // R6: release
        wait_cyc(2);
        check("R6", "released", hold_oe_o, 0);
        cs_n_i = 1; wait_cyc(4);
        // master read
        @(negedge clk); txd_we_i = 1; txd_i = 16'h1234;
        @(negedge clk); txd_we_i = 0;
        rw_i = 1; cs_n_i = 0; wait_cyc(6);
        check("R10", "read dir", xfer_rd_o, 1);
        check("R7", "lanes driven", lane_oe_o, 2'b11);
        // R5: leave the wait pending and raise chip select
        cs_n_i = 1; wait_cyc(1);
        check("R5", "float on cs high", hold_oe_o, 0);
        wait_cyc(4);
        cfg_write(5'b01111); wait_cyc(2);      // release leftover
        cfg_write(5'b01111); wait_cyc(2);      // R6: ready with nothing pending
        rw_i = 0; lane_i = 16'h3C3C; cs_n_i = 0; wait_cyc(6);
        check("R6", "idle ready no effect", hold_oe_o, 1);
        cfg_write(5'b01111); cs_n_i = 1; wait_cyc(4);
        // R8: lane 1 disabled, wait disabled
        cfg_write(5'b10001);                   // also clears flag (R2)
        check("R2", "flag cleared", cfg_rdata_o[4], 0);
        lane_i = 16'h7E81; cs_n_i = 0; wait_cyc(6);
        check("R8", "lane1 kept", rxd_o, 16'h3C81);
        check("R4", "wait disabled", hold_oe_o, 0);
        // R3: long low chip select gives one start
        starts = 0; wait_cyc(40);
        check("R3", "single start", starts, 0);
        cs_n_i = 1; wait_cyc(4);
        starts = 0; cs_n_i = 0; wait_cyc(50);
        check("R3", "one start per select", starts, 1);
        // R2: clear racing a start, start wins
        cs_n_i = 1; wait_cyc(4);
        cs_n_i = 0; wait_cyc(1);
        @(negedge clk); cfg_we_i = 1; cfg_wdata_i = 5'b10001;
        @(negedge clk); cfg_we_i = 0;
        wait_cyc(4);
        cs_n_i = 1; wait_cyc(4);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1500000;
        fails++; checks++;
        done = 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule